// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block checks a secret code that a user enters one digit at a time. A keypad front end, which is not part of this block, presents each digit on `entry_i` and pulses `new_i` for one cycle. The stored code arrives on `code_i` as a packed vector. Digit k of the code sits in bits `[k*DIGIT_W +: DIGIT_W]`, and digit 0 must be entered first. The controller walks through one checking step per digit. In each step, `sel_o` names the stored digit that is routed to the comparator. A strobed entry that equals the selected digit moves the controller to the next step. The step after the last digit is the open state.

A strobed entry that does not match, in any checking step, sends the controller to an error state. The error state traps the controller: further entries are ignored and the lock stays shut until reset. The open state also holds until reset. Both outputs come straight from the state register, so they change only at a clock edge.

Top module: `combo_lock`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the controller is in checking step 0: `open_o` is 0 and `sel_o` is 0.
- R2: `sel_o` equals the index of the current checking step (0, 1 or 2 with the default three digits). It reads 0 in the open state and in the error state.
- R3: At a rising edge where `new_i` is 1 and `entry_i` equals the digit that `sel_o` selects, a checking step that is not the last one moves to the next step.
- R4: A matching strobed entry in the last checking step moves the controller to the open state. `open_o` is 1 from that edge on.
- R5: A strobed entry that differs from the selected digit, in any checking step, moves the controller to the error state. `open_o` stays 0 and `sel_o` becomes 0.
- R6: At an edge where `new_i` is 0, the state does not change, whatever `entry_i` holds.
- R7: The open state ignores all further entries: `open_o` stays 1 until reset.
- R8: The error state ignores all further entries, including a complete correct sequence: `open_o` stays 0 until reset. Reset returns the controller to step 0 from either the open state or the error state.
- R9: The comparison uses the value of `code_i` present at the sampling edge, with no latency of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_i | input | DIGIT_W | Digit entered by the user |
| new_i | input | 1 | One-cycle strobe qualifying `entry_i` |
| code_i | input | NUM_DIGITS*DIGIT_W | Stored code; digit k in bits [k*DIGIT_W +: DIGIT_W] |
| sel_o | output | SEL_W | Index of the stored digit under comparison |
| open_o | output | 1 | 1 when the lock is open, 0 when closed |

## Verification
Every result is due at the first rising edge after the entry is presented. The single state register is the only stage between a strobed entry and both outputs, and the comparator adds no cycle. The bench therefore drives each entry at a falling edge and records the state it expects after that entry. It compares `sel_o` and `open_o` one nanosecond after the next rising edge, so each expected item is popped exactly one edge after it was pushed. Reset values are read while reset is still held, before any edge can act on them.

// File: rtl/lock_pkg.sv
package lock_pkg;
    typedef enum logic [1:0] {
        MODE_CHECK = 2'd0,
        MODE_OPEN  = 2'd1,
        MODE_ERR   = 2'd2
    } lock_mode_e;
endpackage

// File: rtl/lock_digit_mux.sv
module lock_digit_mux #(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 3,
    parameter int SEL_W      = 2
) (
    input  logic [NUM_DIGITS*DIGIT_W-1:0] code_i,
    input  logic [SEL_W-1:0]              sel_i,
    output logic [DIGIT_W-1:0]            digit_o
);
    logic [DIGIT_W-1:0] slice_w [NUM_DIGITS];

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slice
        assign slice_w[g] = code_i[g*DIGIT_W +: DIGIT_W];
    end

    always_comb begin
        digit_o = '0;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (sel_i == SEL_W'(k)) begin
                digit_o = slice_w[k];
            end
        end
    end
endmodule

// File: rtl/lock_cmp.sv
module lock_cmp #(
    parameter int DIGIT_W = 4
) (
    input  logic [DIGIT_W-1:0] a_i,
    input  logic [DIGIT_W-1:0] b_i,
    output logic               eq_o
);
    assign eq_o = (a_i == b_i);
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import lock_pkg::*;
#(
    parameter int NUM_DIGITS = 3,
    parameter int SEL_W      = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             new_i,
    input  logic             match_i,
    output logic [SEL_W-1:0] sel_o,
    output logic             open_o
);
    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_DIGITS - 1);

    typedef struct packed {
        lock_mode_e       mode;
        logic [SEL_W-1:0] idx;
    } lock_state_t;

    lock_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_CHECK: begin
                if (new_i) begin
                    if (!match_i) begin
                        st_d.mode = MODE_ERR;
                        st_d.idx  = '0;
                    end else if (st_q.idx == LAST_IDX) begin
                        st_d.mode = MODE_OPEN;
                        st_d.idx  = '0;
                    end else begin
                        st_d.idx  = st_q.idx + 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_CHECK, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o  = (st_q.mode == MODE_CHECK) ? st_q.idx : '0;
    assign open_o = (st_q.mode == MODE_OPEN);

    // R6: an edge without the strobe keeps the state unchanged
    p_hold_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !new_i |=> $stable(st_q));

    // R3: a match in a step other than the last one advances the index by one
    p_match_adv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == MODE_CHECK && new_i && match_i && st_q.idx != LAST_IDX)
        |=> (st_q.mode == MODE_CHECK && st_q.idx == $past(st_q.idx) + 1'b1));

    // R5: a strobed mismatch in any checking step lands in the error state
    p_mismatch_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.mode == MODE_CHECK && new_i && !match_i) |=> st_q.mode == MODE_ERR);

    // R7: the open state holds until reset
    p_open_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.mode == MODE_OPEN |=> st_q.mode == MODE_OPEN);

    // R8: the error state holds until reset
    p_err_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.mode == MODE_ERR |=> st_q.mode == MODE_ERR);
endmodule

// File: rtl/combo_lock.sv
module combo_lock #(
    parameter int DIGIT_W    = 4,
    parameter int NUM_DIGITS = 3,
    parameter int SEL_W      = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [DIGIT_W-1:0]            entry_i,
    input  logic                          new_i,
    input  logic [NUM_DIGITS*DIGIT_W-1:0] code_i,
    output logic [SEL_W-1:0]              sel_o,
    output logic                          open_o
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_DIGITS - 1);

    logic [DIGIT_W-1:0] ref_digit;
    logic               match;

    lock_digit_mux #(
        .DIGIT_W   (DIGIT_W),
        .NUM_DIGITS(NUM_DIGITS),
        .SEL_W     (SEL_W)
    ) u_mux (
        .code_i (code_i),
        .sel_i  (sel_o),
        .digit_o(ref_digit)
    );

    lock_cmp #(
        .DIGIT_W(DIGIT_W)
    ) u_cmp (
        .a_i (entry_i),
        .b_i (ref_digit),
        .eq_o(match)
    );

    lock_fsm #(
        .NUM_DIGITS(NUM_DIGITS),
        .SEL_W     (SEL_W)
    ) u_fsm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .new_i  (new_i),
        .match_i(match),
        .sel_o  (sel_o),
        .open_o (open_o)
    );

    // R4: the lock opens only right after a strobed entry in the last step
    p_open_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(open_o) |-> ($past(new_i) && $past(sel_o) == LAST_SEL));

    // R2: the select never leaves the range of stored digits
    p_sel_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_o <= LAST_SEL);
endmodule

// File: tb/combo_lock_bench.sv
`timescale 1ns/1ps
module combo_lock_bench;
    localparam int DW = 4;
    localparam int ND = 3;
    localparam int SW = 2;

    typedef struct {
        logic          open;
        logic [SW-1:0] sel;
        string         tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DW-1:0]     entry = '0;
    logic              strobe = 1'b0;
    logic [ND*DW-1:0]  code = 12'h3A7;
    logic [SW-1:0]     sel;
    logic              open_s;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    exp_t q[$];

    // bench model: 0 checking, 1 open, 2 error
    int m_mode = 0;
    int m_idx = 0;

    always #2.5 clk = ~clk;

    combo_lock u_combo_lock (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .entry_i(entry),
        .new_i  (strobe),
        .code_i (code),
        .sel_o  (sel),
        .open_o (open_s)
    );

    function automatic logic [DW-1:0] digit(int k);
        return code[k*DW +: DW];
    endfunction

    task automatic check(string tag, logic a_open, logic [SW-1:0] a_sel,
                         logic e_open, logic [SW-1:0] e_sel);
        checks++;
        if (a_open !== e_open || a_sel !== e_sel) begin
            fails++;
            $display("FAIL %s: open=%0b sel=%0d expected open=%0b sel=%0d",
                     tag, a_open, a_sel, e_open, e_sel);
        end
    endtask

    task automatic step(logic [DW-1:0] e, logic n, string tag);
        exp_t x;
        @(negedge clk);
        entry  = e;
        strobe = n;
        if (n && m_mode == 0) begin
            if (e != digit(m_idx)) begin
                m_mode = 2; m_idx = 0;
            end else if (m_idx == ND - 1) begin
                m_mode = 1; m_idx = 0;
            end else begin
                m_idx++;
            end
        end
        x.open = (m_mode == 1);
        x.sel  = (m_mode == 0) ? SW'(m_idx) : '0;
        x.tag  = tag;
        q.push_back(x);
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        strobe = 1'b0;
        rst_n  = 1'b0;
        m_mode = 0; m_idx = 0;
        #1;
        check(tag, open_s, sel, 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // monitor: compare the item due one edge after it was driven
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                check(x.tag, open_s, sel, x.open, x.sel);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #1;
        check("R1 reset held", open_s, sel, 1'b0, '0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 after release", open_s, sel, 1'b0, '0);

        // R6: no strobe, matching and mismatching values
        step(4'h7, 1'b0, "R6 idle match value");
        step(4'hF, 1'b0, "R6 idle wrong value");
        // R3/R2: advance with gaps
        step(4'h7, 1'b1, "R3 step0 match");
        step(4'h0, 1'b0, "R6 idle in step1");
        step(4'hA, 1'b1, "R3 step1 match");
        step(4'h5, 1'b0, "R6 idle in step2");
        step(4'h3, 1'b1, "R4 last match opens");
        // R7: open absorbs
        step(4'h1, 1'b1, "R7 wrong entry in open");
        step(4'h7, 1'b1, "R7 right entry in open");
        step(4'h0, 1'b0, "R7 idle in open");
        do_reset("R8 reset from open");
        step(4'h0, 1'b0, "R1 step0 after reset");

        // R5 mismatch at step 0, then R8 trap
        step(4'h8, 1'b1, "R5 mismatch step0");
        step(4'h7, 1'b1, "R8 err ignores d0");
        step(4'hA, 1'b1, "R8 err ignores d1");
        step(4'h3, 1'b1, "R8 err ignores d2");
        step(4'h3, 1'b0, "R8 err idle");
        do_reset("R8 reset from err");

        // R5 mismatch at step 1
        step(4'h7, 1'b1, "R3 step0 match again");
        step(4'hB, 1'b1, "R5 mismatch step1");
        step(4'h3, 1'b1, "R8 err holds");
        do_reset("R8 reset again");

        // R5 mismatch at last step
        step(4'h7, 1'b1, "R3 step0");
        step(4'hA, 1'b1, "R3 step1");
        step(4'h2, 1'b1, "R5 mismatch last step");
        do_reset("R8 reset after last mismatch");

        // R9: code change takes effect at once
        @(negedge clk);
        code = 12'h5C1;
        step(4'h1, 1'b1, "R9 new code digit0");
        step(4'hC, 1'b1, "R9 new code digit1");
        step(4'h5, 1'b1, "R9 new code opens");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule